// File: doc/BRIEF.md
# Single-Error-Correcting Hamming Codec

This block protects short data words with a systematic Hamming code. The encoder path takes a data word and returns a codeword. The data bits sit at the top of the codeword and the even-parity check bits sit at the bottom. The decoder path takes a received codeword and computes its syndrome. If the syndrome names a bit, the decoder flips that bit and returns the repaired data field, with flags and the index of the repaired bit.

A single mode input selects one of two codes, and both paths use it:

- **Short mode** (`mode_i = 0`): 4 data bits and 3 check bits, 7 bits in all.
- **Long mode** (`mode_i = 1`): 5 data bits and 4 check bits, 9 bits in all. This is a shortened code.

Both codes have a minimum distance of three. They correct one error; they cannot also detect a second. In long mode, the syndromes that match no column are reported as uncorrectable. Each path is one register stage with a valid strobe. There is no back-pressure.

Top module: `hamming_codec`

## Requirements
- R1: In short mode, `enc_code_o[6:3]` carries data bits 3..0 and `enc_code_o[8:7]` is zero. The check bits are `[2] = d3^d2^d1`, `[1] = d3^d2^d0` and `[0] = d3^d1^d0`. `enc_data_i[4]` is ignored.
- R2: In long mode, `enc_code_o[8:4]` carries data bits 4..0. The check bits are `[3] = d4^d3^d2^d1`, `[2] = d4^d3^d2^d0`, `[1] = d4^d3^d1^d0` and `[0] = d4^d2^d1^d0`.
- R3: Each output valid rises exactly one clock after its input valid. No output valid appears without a matching input.
- R4: In short mode, syndromes 001, 010 and 100 point at check bits 0, 1 and 2 (positions 0, 1, 2). The decoder sets `dec_corrected_o`, reports that position, and leaves the data unchanged.
- R5: In short mode, syndromes 011, 101, 110 and 111 point at data bits 0, 1, 2 and 3 (positions 3..6). The decoder flips that bit, sets `dec_corrected_o` and reports the position.
- R6: A zero syndrome clears both flags and sets `dec_pos_o` to 0. The received data field is returned as is.
- R7: In long mode, a single flipped bit at any position 0..8 is repaired. `dec_pos_o` equals that bit index, and `dec_corrected_o` is set.
- R8: In long mode, a nonzero syndrome that matches no column (any two-bit syndrome) sets `dec_uncorrectable_o` and clears `dec_corrected_o`. `dec_pos_o` is 0 and the received data field passes through unchanged.
- R9: In short mode, `dec_code_i[8:7]` is ignored, `dec_data_o[4]` is 0, and `dec_uncorrectable_o` never rises.
- R10: In short mode, two flipped bits cannot be told apart from a single error. The decoder repairs the position whose column equals the XOR of the two flipped columns and sets `dec_corrected_o`.
- R11: While reset is held, both valids and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = short code (7 bits), 1 = long code (9 bits) |
| enc_valid_i | input | 1 | Encoder input strobe |
| enc_data_i | input | 5 | Data to encode (bit 4 used in long mode only) |
| enc_valid_o | output | 1 | Encoder result strobe |
| enc_code_o | output | 9 | Codeword, data on top, check bits at the bottom |
| dec_valid_i | input | 1 | Decoder input strobe |
| dec_code_i | input | 9 | Received codeword |
| dec_valid_o | output | 1 | Decoder result strobe |
| dec_data_o | output | 5 | Repaired data field |
| dec_corrected_o | output | 1 | A single bit was flipped |
| dec_uncorrectable_o | output | 1 | Long-mode syndrome matched no column |
| dec_pos_o | output | 4 | Index of the flipped bit |

## Verification
Every encoder and decoder result is due one rising edge after the falling edge on which its input strobe was driven. Each queued expectation carries the cycle in which it is due. The monitor samples on the falling edge and checks two things. First, a valid strobe arrives in exactly that cycle. Second, no strobe appears with an empty queue and no due item is missed. The expected codewords, positions and flags are worked out from the parity equations and syndrome tables in the requirements. For two-bit short-mode errors, the expected values come from a syndrome that the bench recomputes itself.

// File: rtl/hcodec_pkg.sv
package hcodec_pkg;

    localparam int DATA_W  = 5;
    localparam int CHK_W   = 4;
    localparam int CODE_W  = DATA_W + CHK_W;
    localparam int SYN_W   = CHK_W;
    localparam int POS_W   = $clog2(CODE_W);
    localparam int SHORT_DATA_W = 4;
    localparam int SHORT_CHK_W  = 3;

    typedef enum logic {
        MODE_SHORT = 1'b0,
        MODE_LONG  = 1'b1
    } code_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              corrected;
        logic              uncorrectable;
        logic [POS_W-1:0]  pos;
    } dec_result_t;

    function automatic int chk_len(code_mode_e m);
        return (m == MODE_SHORT) ? SHORT_CHK_W : CHK_W;
    endfunction

    function automatic int data_len(code_mode_e m);
        return (m == MODE_SHORT) ? SHORT_DATA_W : DATA_W;
    endfunction

    function automatic int code_len(code_mode_e m);
        return chk_len(m) + data_len(m);
    endfunction

    // Parity-check column for codeword position p (check bits sit low).
    function automatic logic [SYN_W-1:0] column(code_mode_e m, int p);
        logic [SYN_W-1:0] c;
        c = '0;
        if (m == MODE_SHORT) begin
            case (p)
                0: c = 4'b0001;
                1: c = 4'b0010;
                2: c = 4'b0100;
                3: c = 4'b0011;
                4: c = 4'b0101;
                5: c = 4'b0110;
                6: c = 4'b0111;
                default: c = '0;
            endcase
        end else begin
            case (p)
                0: c = 4'b0001;
                1: c = 4'b0010;
                2: c = 4'b0100;
                3: c = 4'b1000;
                4: c = 4'b0111;
                5: c = 4'b1011;
                6: c = 4'b1101;
                7: c = 4'b1110;
                8: c = 4'b1111;
                default: c = '0;
            endcase
        end
        return c;
    endfunction

    // Keep only the bits that belong to the selected code.
    function automatic logic [CODE_W-1:0] trim_word(code_mode_e m, logic [CODE_W-1:0] w);
        logic [CODE_W-1:0] t;
        t = '0;
        for (int p = 0; p < CODE_W; p++) begin
            if (p < code_len(m)) t[p] = w[p];
        end
        return t;
    endfunction

    function automatic logic [CODE_W-1:0] encode_word(code_mode_e m, logic [DATA_W-1:0] d);
        logic [SYN_W-1:0]  chk;
        logic [CODE_W-1:0] w;
        chk = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < data_len(m) && d[i]) chk ^= column(m, i + chk_len(m));
        end
        if (m == MODE_SHORT)
            w = {2'b00, d[SHORT_DATA_W-1:0], chk[SHORT_CHK_W-1:0]};
        else
            w = {d, chk};
        return w;
    endfunction

    function automatic logic [SYN_W-1:0] syndrome_of(code_mode_e m, logic [CODE_W-1:0] w);
        logic [SYN_W-1:0] s;
        s = '0;
        for (int p = 0; p < CODE_W; p++) begin
            if (p < code_len(m) && w[p]) s ^= column(m, p);
        end
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] data_field(code_mode_e m, logic [CODE_W-1:0] w);
        if (m == MODE_SHORT)
            return {1'b0, w[SHORT_CHK_W +: SHORT_DATA_W]};
        return w[CHK_W +: DATA_W];
    endfunction

endpackage

// File: rtl/hc_encoder.sv
module hc_encoder
    import hcodec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  code_mode_e        mode_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [CODE_W-1:0] code_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            code_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) code_o <= encode_word(mode_i, data_i);
        end
    end

    a_r3_enc_latency: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);
    a_r3_enc_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !valid_o);
    a_r1_short_layout: assert property (@(posedge clk) disable iff (rst)
        (valid_i && mode_i == MODE_SHORT) |=>
            (code_o[6:3] == $past(data_i[3:0]) && code_o[8:7] == 2'b00));
    a_r2_long_layout: assert property (@(posedge clk) disable iff (rst)
        (valid_i && mode_i == MODE_LONG) |=> (code_o[8:4] == $past(data_i)));

endmodule

// File: rtl/hc_syndrome.sv
module hc_syndrome
    import hcodec_pkg::*;
(
    input  code_mode_e        mode_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] trimmed_o,
    output logic [SYN_W-1:0]  syn_o
);

    always_comb begin
        trimmed_o = trim_word(mode_i, code_i);
        syn_o     = syndrome_of(mode_i, trimmed_o);
    end

endmodule

// File: rtl/hc_locate.sv
module hc_locate
    import hcodec_pkg::*;
(
    input  code_mode_e       mode_i,
    input  logic [SYN_W-1:0] syn_i,
    output logic             hit_o,
    output logic [POS_W-1:0] pos_o
);

    logic [CODE_W-1:0] match;

    for (genvar p = 0; p < CODE_W; p++) begin : g_col
        assign match[p] = (syn_i != '0) && (p < code_len(mode_i)) &&
                          (syn_i == column(mode_i, p));
    end

    always_comb begin
        hit_o = |match;
        pos_o = '0;
        for (int p = 0; p < CODE_W; p++) begin
            if (match[p]) pos_o = POS_W'(p);
        end
    end

endmodule

// File: rtl/hc_decoder.sv
module hc_decoder
    import hcodec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  code_mode_e        mode_i,
    input  logic              valid_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              valid_o,
    output dec_result_t       res_o
);

    logic [CODE_W-1:0] trimmed;
    logic [SYN_W-1:0]  syn;
    logic              hit;
    logic [POS_W-1:0]  pos;
    dec_result_t       res_d;
    logic [CODE_W-1:0] flip;

    hc_syndrome u_syn (
        .mode_i    (mode_i),
        .code_i    (code_i),
        .trimmed_o (trimmed),
        .syn_o     (syn)
    );

    hc_locate u_loc (
        .mode_i (mode_i),
        .syn_i  (syn),
        .hit_o  (hit),
        .pos_o  (pos)
    );

    always_comb begin
        flip  = hit ? (CODE_W'(1) << pos) : '0;
        res_d.data          = data_field(mode_i, trimmed ^ flip);
        res_d.corrected     = hit;
        res_d.uncorrectable = (syn != '0) && !hit;
        res_d.pos           = hit ? pos : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            res_o   <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) res_o <= res_d;
        end
    end

    a_r3_dec_latency: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);
    a_r6_clean_no_flags: assert property (@(posedge clk) disable iff (rst)
        (valid_i && syn == '0) |=> (!res_o.corrected && !res_o.uncorrectable));
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> !(res_o.corrected && res_o.uncorrectable));
    a_r9_short_never_uncorr: assert property (@(posedge clk) disable iff (rst)
        (valid_i && mode_i == MODE_SHORT) |=> (!res_o.uncorrectable && !res_o.data[4]));
    a_r7_pos_in_range: assert property (@(posedge clk) disable iff (rst)
        (valid_o && res_o.corrected) |-> (int'(res_o.pos) < CODE_W));

endmodule

// File: rtl/hamming_codec.sv
module hamming_codec
    import hcodec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_i,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_valid_o,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic              dec_valid_i,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_corrected_o,
    output logic              dec_uncorrectable_o,
    output logic [POS_W-1:0]  dec_pos_o
);

    code_mode_e  mode;
    dec_result_t dres;

    assign mode = code_mode_e'(mode_i);

    hc_encoder u_enc (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (mode),
        .valid_i (enc_valid_i),
        .data_i  (enc_data_i),
        .valid_o (enc_valid_o),
        .code_o  (enc_code_o)
    );

    hc_decoder u_dec (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (mode),
        .valid_i (dec_valid_i),
        .code_i  (dec_code_i),
        .valid_o (dec_valid_o),
        .res_o   (dres)
    );

    assign dec_data_o          = dres.data;
    assign dec_corrected_o     = dres.corrected;
    assign dec_uncorrectable_o = dres.uncorrectable;
    assign dec_pos_o           = dres.pos;

    a_r11_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!enc_valid_o && !dec_valid_o && enc_code_o == '0 && dec_pos_o == '0));

endmodule

// File: tb/hamming_codec_bench.sv
module hamming_codec_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_i = 1'b0;
    logic       enc_valid_i = 1'b0;
    logic [4:0] enc_data_i = '0;
    logic       enc_valid_o;
    logic [8:0] enc_code_o;
    logic       dec_valid_i = 1'b0;
    logic [8:0] dec_code_i = '0;
    logic       dec_valid_o;
    logic [4:0] dec_data_o;
    logic       dec_corrected_o;
    logic       dec_uncorrectable_o;
    logic [3:0] dec_pos_o;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    typedef struct {
        logic [8:0] code;
        int         due;
        string      tag;
    } enc_item_t;

    typedef struct {
        logic [4:0] data;
        logic       corr;
        logic       unc;
        logic [3:0] pos;
        int         due;
        string      tag;
    } dec_item_t;

    enc_item_t enc_q[$];
    dec_item_t dec_q[$];
    enc_item_t ei;
    dec_item_t di;

    hamming_codec u_hamming_codec (
        .clk                 (clk),
        .rst                 (rst),
        .mode_i              (mode_i),
        .enc_valid_i         (enc_valid_i),
        .enc_data_i          (enc_data_i),
        .enc_valid_o         (enc_valid_o),
        .enc_code_o          (enc_code_o),
        .dec_valid_i         (dec_valid_i),
        .dec_code_i          (dec_code_i),
        .dec_valid_o         (dec_valid_o),
        .dec_data_o          (dec_data_o),
        .dec_corrected_o     (dec_corrected_o),
        .dec_uncorrectable_o (dec_uncorrectable_o),
        .dec_pos_o           (dec_pos_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected codewords straight from the parity equations of R1 and R2.
    function automatic logic [8:0] ref_short(logic [3:0] d);
        return {2'b00, d, d[3]^d[2]^d[1], d[3]^d[2]^d[0], d[3]^d[1]^d[0]};
    endfunction

    function automatic logic [8:0] ref_long(logic [4:0] d);
        return {d, d[4]^d[3]^d[2]^d[1], d[4]^d[3]^d[2]^d[0],
                   d[4]^d[3]^d[1]^d[0], d[4]^d[2]^d[1]^d[0]};
    endfunction

    // Short-mode syndrome table of R4/R5, used for the two-bit case of R10.
    function automatic int short_pos(logic [6:0] r);
        logic [2:0] s;
        s = ref_short(r[6:3])[2:0] ^ r[2:0];
        case (s)
            3'b001: return 0;
            3'b010: return 1;
            3'b100: return 2;
            3'b011: return 3;
            3'b101: return 4;
            3'b110: return 5;
            3'b111: return 6;
            default: return -1;
        endcase
    endfunction

    task automatic check(bit ok, string req, string act, string exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            enc_valid_i = 1'b0;
            dec_valid_i = 1'b0;
        end
    endtask

    task automatic drive_enc(logic m, logic [4:0] d, logic [8:0] exp, string tag);
        enc_item_t it;
        @(negedge clk);
        mode_i      = m;
        enc_valid_i = 1'b1;
        enc_data_i  = d;
        dec_valid_i = 1'b0;
        it.code = exp;
        it.due  = cyc + 1;
        it.tag  = tag;
        enc_q.push_back(it);
    endtask

    task automatic drive_dec(logic m, logic [8:0] code, logic [4:0] ed, logic ec,
                             logic eu, logic [3:0] ep, string tag);
        dec_item_t it;
        @(negedge clk);
        mode_i      = m;
        dec_valid_i = 1'b1;
        dec_code_i  = code;
        enc_valid_i = 1'b0;
        it.data = ed;
        it.corr = ec;
        it.unc  = eu;
        it.pos  = ep;
        it.due  = cyc + 1;
        it.tag  = tag;
        dec_q.push_back(it);
    endtask

    // Scoreboard monitor: results sampled on the falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (enc_valid_o) begin
                if (enc_q.size() == 0) begin
                    check(0, "R3", "enc strobe", "no strobe");
                end else begin
                    ei = enc_q.pop_front();
                    check(ei.due == cyc, "R3", $sformatf("cycle %0d", cyc), $sformatf("cycle %0d", ei.due));
                    check(enc_code_o == ei.code, ei.tag, $sformatf("%b", enc_code_o), $sformatf("%b", ei.code));
                end
            end else if (enc_q.size() > 0 && enc_q[0].due <= cyc) begin
                ei = enc_q.pop_front();
                check(0, "R3", "no enc strobe", $sformatf("strobe at %0d", ei.due));
            end
            if (dec_valid_o) begin
                if (dec_q.size() == 0) begin
                    check(0, "R3", "dec strobe", "no strobe");
                end else begin
                    di = dec_q.pop_front();
                    check(di.due == cyc, "R3", $sformatf("cycle %0d", cyc), $sformatf("cycle %0d", di.due));
                    check(dec_data_o == di.data && dec_corrected_o == di.corr &&
                          dec_uncorrectable_o == di.unc && dec_pos_o == di.pos, di.tag,
                          $sformatf("d=%b c=%b u=%b p=%0d", dec_data_o, dec_corrected_o, dec_uncorrectable_o, dec_pos_o),
                          $sformatf("d=%b c=%b u=%b p=%0d", di.data, di.corr, di.unc, di.pos));
                end
            end else if (dec_q.size() > 0 && dec_q[0].due <= cyc) begin
                di = dec_q.pop_front();
                check(0, "R3", "no dec strobe", $sformatf("strobe at %0d", di.due));
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [8:0] cw;
        logic [8:0] rx;
        // R11: outputs held quiet during reset, even with inputs active
        enc_valid_i = 1'b1;
        dec_valid_i = 1'b1;
        dec_code_i  = 9'h1FF;
        repeat (3) @(negedge clk);
        check(!enc_valid_o && !dec_valid_o && enc_code_o == '0 && dec_data_o == '0 &&
              !dec_corrected_o && !dec_uncorrectable_o && dec_pos_o == '0, "R11",
              $sformatf("ev=%b dv=%b code=%b", enc_valid_o, dec_valid_o, enc_code_o), "all zero");
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        idle(2);

        // R1: short encode, every data value; bit 4 of input toggled and ignored
        for (int d = 0; d < 16; d++)
            drive_enc(1'b0, {d[0], d[3:0]}, ref_short(d[3:0]), "R1");
        idle(2);
        // R2: long encode, every data value, with gaps for R3
        for (int d = 0; d < 32; d++) begin
            drive_enc(1'b1, d[4:0], ref_long(d[4:0]), "R2");
            if (d % 7 == 0) idle(1);
        end
        idle(2);

        // Short decode: clean (R6), check-bit errors (R4), data-bit errors (R5)
        for (int d = 0; d < 16; d++) begin
            cw = ref_short(d[3:0]);
            drive_dec(1'b0, cw, {1'b0, d[3:0]}, 1'b0, 1'b0, 4'd0, "R6");
            for (int p = 0; p < 7; p++)
                drive_dec(1'b0, cw ^ (9'd1 << p), {1'b0, d[3:0]}, 1'b1, 1'b0, 4'(p),
                          (p < 3) ? "R4" : "R5");
        end
        idle(2);

        // R9: junk in bits 8:7 ignored in short mode
        for (int d = 0; d < 16; d += 5) begin
            cw = ref_short(d[3:0]);
            drive_dec(1'b0, cw | 9'h180, {1'b0, d[3:0]}, 1'b0, 1'b0, 4'd0, "R9");
            drive_dec(1'b0, (cw ^ 9'd8) | 9'h100, {1'b0, d[3:0]}, 1'b1, 1'b0, 4'd3, "R9");
        end
        idle(2);

        // Long decode: clean (R6) and every single error (R7)
        for (int d = 0; d < 32; d++) begin
            cw = ref_long(d[4:0]);
            drive_dec(1'b1, cw, d[4:0], 1'b0, 1'b0, 4'd0, "R6");
            for (int p = 0; p < 9; p++)
                drive_dec(1'b1, cw ^ (9'd1 << p), d[4:0], 1'b1, 1'b0, 4'(p), "R7");
        end
        idle(2);

        // R8: double errors giving two-bit syndromes in long mode
        for (int d = 0; d < 32; d += 3) begin
            cw = ref_long(d[4:0]);
            rx = cw ^ 9'b000000011;  // syndrome 0011
            drive_dec(1'b1, rx, rx[8:4], 1'b0, 1'b1, 4'd0, "R8");
            rx = cw ^ 9'b000001010;  // syndrome 1010
            drive_dec(1'b1, rx, rx[8:4], 1'b0, 1'b1, 4'd0, "R8");
            rx = cw ^ 9'b000110000;  // i0,i1: syndrome 1100
            drive_dec(1'b1, rx, rx[8:4], 1'b0, 1'b1, 4'd0, "R8");
            rx = cw ^ 9'b011000000;  // i2,i3: syndrome 0011
            drive_dec(1'b1, rx, rx[8:4], 1'b0, 1'b1, 4'd0, "R8");
        end
        idle(2);

        // R10: every two-bit error in short mode is taken as a single error
        for (int d = 0; d < 16; d += 5) begin
            cw = ref_short(d[3:0]);
            for (int a = 0; a < 7; a++) begin
                for (int b = a + 1; b < 7; b++) begin
                    int q;
                    logic [8:0] fx;
                    rx = cw ^ (9'd1 << a) ^ (9'd1 << b);
                    q  = short_pos(rx[6:0]);
                    fx = rx ^ (9'd1 << q);
                    drive_dec(1'b0, rx, {1'b0, fx[6:3]}, 1'b1, 1'b0, 4'(q), "R10");
                end
            end
        end
        idle(4);

        check(enc_q.size() == 0 && dec_q.size() == 0, "R3",
              $sformatf("%0d/%0d pending", enc_q.size(), dec_q.size()), "0/0 pending");
        finish_run();
    end

endmodule